// File: doc/BRIEF.md
# Shared Four-Bank Request Scheduler with Subarray Conflict Tracking

This block orders memory requests for a group of four neighbouring banks that share one request queue. Each request names an access direction (row or column), a bank within the group, a subarray within that bank, an address and a read or write flag. A request is served as two commands on one shared address/command path: first an activate that opens the subarray, then the read or write access itself. The two are chosen by separate first-level pickers, each taking the oldest request that may go. A second-level choice then hands the single path to an access before any activate.

A subarray counts as busy from its activate until the bank sequencer reports a completion for it. A busy subarray blocks every later request to it, whatever its direction, so row and column traffic to one subarray is serialized. Requests to other subarrays, even in the same bank, keep flowing.

Requests enter on a valid/ready port: a request is taken on a clock edge where `enq_valid` and `enq_ready` are both high, and `enq_ready` is low only while the queue is full. Commands leave on a valid/ready port: a command is taken on an edge where `cmd_valid` and `cmd_ready` are both high. While it is not taken, the offer is worked out afresh each cycle and may change, so the sequencer acts only on the handshake. Completions are a plain one-cycle pulse.

Top module: `bank_group_sched`

## Requirements
- R1: After reset the queue is empty, every subarray is idle, `enq_ready` is 1 and `cmd_valid` is 0.
- R2: The queue holds up to 16 requests. Each request has `enq_orient` (0 = row, 1 = column), a 2-bit bank, a 3-bit subarray, an address and `enq_write` (1 = write). A request taken at an edge can be offered in the cycle that follows.
- R3: Each request produces an activate (`cmd_access` = 0) and then an access (`cmd_access` = 1). Both carry the request's direction, bank, subarray, address and write flag. The request leaves the queue on the handshake of its access.
- R4: An activate is offered only for a subarray that is not busy. Its handshake marks that bank/subarray pair busy in both directions, so a second request to the same pair, row or column, waits until a completion.
- R5: A request to a subarray other than the busy ones may be activated and accessed while those subarrays stay busy, including another subarray of the same bank.
- R6: When any request has been activated but not yet accessed, the offered command is an access.
- R7: Among activates, the oldest request whose subarray is idle is offered. Among accesses, the oldest activated request is offered.
- R8: With 16 requests queued, `enq_ready` is 0 and `enq_valid` has no effect.
- R9: While `cmd_valid` is 1 and `cmd_ready` is 0, no request advances and no subarray becomes busy. At most one command is taken per cycle.
- R10: A pulse on `cpl_valid` makes the pair {`cpl_bank`, `cpl_sub`} idle from the next cycle. A pulse for an idle pair changes nothing. A pulse in the same cycle as an activate handshake to the same pair leaves it busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enq_valid | input | 1 | Request offered |
| enq_ready | output | 1 | Queue has a free place |
| enq_orient | input | 1 | 0 row, 1 column |
| enq_bank | input | 2 | Bank in the group |
| enq_sub | input | 3 | Subarray in the bank |
| enq_addr | input | ADDR_W | Request address |
| enq_write | input | 1 | 1 write, 0 read |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Sequencer takes the command |
| cmd_access | output | 1 | 0 activate, 1 read/write access |
| cmd_orient | output | 1 | Direction of the command |
| cmd_bank | output | 2 | Target bank |
| cmd_sub | output | 3 | Target subarray |
| cmd_addr | output | ADDR_W | Target address |
| cmd_write | output | 1 | Write flag of the request |
| cpl_valid | input | 1 | Completion pulse |
| cpl_bank | input | 2 | Bank of the completed subarray |
| cpl_sub | input | 3 | Completed subarray |

## Verification
The assertions check these on every cycle:
- the queue never holds more than its depth, and a full queue with no access handshake stays the same size;
- no activate is offered for a busy subarray, and an activate handshake leaves its subarray busy;
- the cycle after an activate handshake offers an access;
- busy bits do not change during a stall without a completion, and no busy bit drops without a completion.

Only the bench's scenarios show the rest, by comparing every offered command with a behavioural model:
- that the oldest request wins;
- that a column request really waits for a row access to the same subarray to complete;
- that other subarrays of the same bank proceed meanwhile;
- that a completion for an idle subarray leaves a blocked request blocked.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
  typedef enum logic {
    CMD_ACTIVATE = 1'b0,
    CMD_ACCESS   = 1'b1
  } cmd_kind_e;

  typedef enum logic {
    DIR_ROW = 1'b0,
    DIR_COL = 1'b1
  } dir_e;
endpackage

// File: rtl/bgs_oldest.sv
// Lowest index wins: index 0 is the oldest queue place.
module bgs_oldest #(
  parameter int N = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/bgs_busy.sv
// One bit per bank/subarray pair; clear applies before set.
module bgs_busy #(
  parameter int SLOTS = 32,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [SW-1:0]    set_idx,
  input  logic             clr_en,
  input  logic [SW-1:0]    clr_idx,
  output logic [SLOTS-1:0] busy
);
  logic [SLOTS-1:0] set_m, clr_m;

  always_comb begin
    set_m = '0;
    clr_m = '0;
    if (set_en) set_m[set_idx] = 1'b1;
    if (clr_en) clr_m[clr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= '0;
    else        busy <= (busy & ~clr_m) | set_m;
  end
endmodule

// File: rtl/bgs_queue.sv
// Collapsing age-ordered queue: place 0 is oldest, removal shifts younger down.
module bgs_queue #(
  parameter int DEPTH  = 16,
  parameter int BANK_W = 2,
  parameter int SUB_W  = 3,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              push_orient,
  input  logic [BANK_W-1:0] push_bank,
  input  logic [SUB_W-1:0]  push_sub,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              push_write,
  input  logic              pop,
  input  logic [IDX_W-1:0]  pop_idx,
  input  logic              mark,
  input  logic [IDX_W-1:0]  mark_idx,
  output logic [CNT_W-1:0]  occ,
  output logic              full,
  output logic [DEPTH-1:0]  e_valid,
  output logic [DEPTH-1:0]  e_phase,
  output logic [DEPTH-1:0]  e_orient,
  output logic [DEPTH-1:0]  e_write,
  output logic [BANK_W-1:0] e_bank [DEPTH],
  output logic [SUB_W-1:0]  e_sub  [DEPTH],
  output logic [ADDR_W-1:0] e_addr [DEPTH]
);
  logic [CNT_W-1:0] wr_pos;

  assign wr_pos = occ - CNT_W'(pop);
  assign full   = (occ == CNT_W'(DEPTH));

  always_comb begin
    for (int i = 0; i < DEPTH; i++) e_valid[i] = (CNT_W'(i) < occ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ + CNT_W'(push) - CNT_W'(pop);
  end

  // activation state, reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_phase <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (push && (CNT_W'(i) == wr_pos))
          e_phase[i] <= 1'b0;
        else if (pop && (IDX_W'(i) >= pop_idx))
          e_phase[i] <= (i < DEPTH - 1) ? e_phase[(i < DEPTH - 1) ? i + 1 : i] : 1'b0;
        else if (mark && (IDX_W'(i) == mark_idx))
          e_phase[i] <= 1'b1;
      end
    end
  end

  // payload, no reset needed
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push && (CNT_W'(i) == wr_pos)) begin
        e_orient[i] <= push_orient;
        e_write[i]  <= push_write;
        e_bank[i]   <= push_bank;
        e_sub[i]    <= push_sub;
        e_addr[i]   <= push_addr;
      end else if (pop && (IDX_W'(i) >= pop_idx) && (i < DEPTH - 1)) begin
        e_orient[i] <= e_orient[i + 1];
        e_write[i]  <= e_write[i + 1];
        e_bank[i]   <= e_bank[i + 1];
        e_sub[i]    <= e_sub[i + 1];
        e_addr[i]   <= e_addr[i + 1];
      end
    end
  end
endmodule

// File: rtl/bank_group_sched.sv
module bank_group_sched #(
  parameter int DEPTH     = 16,
  parameter int NUM_BANKS = 4,
  parameter int NUM_SUBS  = 8,
  parameter int ADDR_W    = 32,
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int SUB_W     = $clog2(NUM_SUBS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_valid,
  output logic              enq_ready,
  input  logic              enq_orient,
  input  logic [BANK_W-1:0] enq_bank,
  input  logic [SUB_W-1:0]  enq_sub,
  input  logic [ADDR_W-1:0] enq_addr,
  input  logic              enq_write,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_access,
  output logic              cmd_orient,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [SUB_W-1:0]  cmd_sub,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_write,
  input  logic              cpl_valid,
  input  logic [BANK_W-1:0] cpl_bank,
  input  logic [SUB_W-1:0]  cpl_sub
);
  import bgs_pkg::*;

  localparam int SLOT_W    = BANK_W + SUB_W;
  localparam int NUM_SLOTS = NUM_BANKS * NUM_SUBS;
  localparam int IDX_W     = $clog2(DEPTH);
  localparam int CNT_W     = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]  occ;
  logic              full;
  logic [DEPTH-1:0]  e_valid, e_phase, e_orient, e_write;
  logic [BANK_W-1:0] e_bank [DEPTH];
  logic [SUB_W-1:0]  e_sub  [DEPTH];
  logic [ADDR_W-1:0] e_addr [DEPTH];
  logic [SLOT_W-1:0] slot_of [DEPTH];

  logic [NUM_SLOTS-1:0] busy_vec;
  logic [DEPTH-1:0]     act_req, acc_req;
  logic                 act_found, acc_found;
  logic [IDX_W-1:0]     act_idx, acc_idx, sel_idx;
  cmd_kind_e            sel_kind;
  logic                 grant, push, pop, mark;

  // first level: eligibility per queue place
  for (genvar i = 0; i < DEPTH; i++) begin : g_elig
    assign slot_of[i] = {e_bank[i], e_sub[i]};
    assign act_req[i] = e_valid[i] & ~e_phase[i] & ~busy_vec[slot_of[i]];
    assign acc_req[i] = e_valid[i] &  e_phase[i];
  end

  bgs_oldest #(.N(DEPTH)) u_act_pick (
    .req(act_req), .found(act_found), .idx(act_idx)
  );

  bgs_oldest #(.N(DEPTH)) u_acc_pick (
    .req(acc_req), .found(acc_found), .idx(acc_idx)
  );

  // second level: accesses beat activates on the shared path
  always_comb begin
    if (acc_found) begin
      sel_kind = CMD_ACCESS;
      sel_idx  = acc_idx;
    end else begin
      sel_kind = CMD_ACTIVATE;
      sel_idx  = act_idx;
    end
  end

  assign cmd_valid  = acc_found | act_found;
  assign cmd_access = (sel_kind == CMD_ACCESS);
  assign cmd_orient = e_orient[sel_idx];
  assign cmd_write  = e_write[sel_idx];
  assign cmd_bank   = e_bank[sel_idx];
  assign cmd_sub    = e_sub[sel_idx];
  assign cmd_addr   = e_addr[sel_idx];

  assign grant     = cmd_valid & cmd_ready;
  assign pop       = grant & (sel_kind == CMD_ACCESS);
  assign mark      = grant & (sel_kind == CMD_ACTIVATE);
  assign enq_ready = ~full;
  assign push      = enq_valid & enq_ready;

  bgs_queue #(
    .DEPTH(DEPTH), .BANK_W(BANK_W), .SUB_W(SUB_W), .ADDR_W(ADDR_W)
  ) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_orient(enq_orient), .push_bank(enq_bank),
    .push_sub(enq_sub), .push_addr(enq_addr), .push_write(enq_write),
    .pop(pop), .pop_idx(sel_idx), .mark(mark), .mark_idx(sel_idx),
    .occ(occ), .full(full), .e_valid(e_valid), .e_phase(e_phase),
    .e_orient(e_orient), .e_write(e_write), .e_bank(e_bank),
    .e_sub(e_sub), .e_addr(e_addr)
  );

  bgs_busy #(.SLOTS(NUM_SLOTS)) u_busy (
    .clk(clk), .rst_n(rst_n),
    .set_en(mark), .set_idx(slot_of[sel_idx]),
    .clr_en(cpl_valid), .clr_idx({cpl_bank, cpl_sub}),
    .busy(busy_vec)
  );
endmodule

// File: rtl/bank_group_sched_chk.sv
module bank_group_sched_chk #(
  parameter int DEPTH     = 16,
  parameter int NUM_SLOTS = 32,
  parameter int SLOT_W    = 5,
  parameter int CNT_W     = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 enq_ready,
  input logic                 cmd_valid,
  input logic                 cmd_ready,
  input logic                 cmd_access,
  input logic                 cpl_valid,
  input logic [SLOT_W-1:0]    cmd_slot,
  input logic [NUM_SLOTS-1:0] busy_vec,
  input logic [CNT_W-1:0]     occ
);
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));

  // R8
  full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enq_ready && !(cmd_valid && cmd_ready && cmd_access)) |=> occ == $past(occ));

  // R4
  act_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_access) |-> !busy_vec[cmd_slot]);

  // R4
  act_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_access) |=> busy_vec[$past(cmd_slot)]);

  // R6
  acc_after_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_access) |=> (cmd_valid && cmd_access));

  // R9
  stall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !cpl_valid) |=> busy_vec == $past(busy_vec));

  // R10
  clear_only_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpl_valid |=> (($past(busy_vec) & ~busy_vec) == '0));
endmodule

bind bank_group_sched bank_group_sched_chk #(
  .DEPTH(DEPTH), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enq_ready(enq_ready), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_access(cmd_access), .cpl_valid(cpl_valid),
  .cmd_slot({cmd_bank, cmd_sub}), .busy_vec(busy_vec), .occ(occ)
);

// File: tb/bank_group_sched_tb_top.sv
`timescale 1ns/1ps
module bank_group_sched_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enq_valid = 1'b0, enq_orient = 1'b0, enq_write = 1'b0;
  logic [1:0]  enq_bank = '0;
  logic [2:0]  enq_sub = '0;
  logic [31:0] enq_addr = '0;
  logic        enq_ready;
  logic        cmd_valid, cmd_access, cmd_orient, cmd_write;
  logic        cmd_ready = 1'b1;
  logic [1:0]  cmd_bank;
  logic [2:0]  cmd_sub;
  logic [31:0] cmd_addr;
  logic        cpl_valid = 1'b0;
  logic [1:0]  cpl_bank = '0;
  logic [2:0]  cpl_sub = '0;

  int total = 0, bad = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  bank_group_sched dut_i (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_orient(enq_orient),
    .enq_bank(enq_bank), .enq_sub(enq_sub), .enq_addr(enq_addr), .enq_write(enq_write),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_access(cmd_access),
    .cmd_orient(cmd_orient), .cmd_bank(cmd_bank), .cmd_sub(cmd_sub),
    .cmd_addr(cmd_addr), .cmd_write(cmd_write),
    .cpl_valid(cpl_valid), .cpl_bank(cpl_bank), .cpl_sub(cpl_sub)
  );

  // behavioural reference model
  typedef struct {
    bit          orient;
    int          bank;
    int          sub;
    logic [31:0] addr;
    bit          wr;
    bit          opened;
  } req_t;

  req_t mq[$];
  bit   mbusy[32];
  bit   x_valid, x_acc, x_ready;
  int   x_idx;

  function automatic void model_eval();
    x_valid = 0; x_acc = 0; x_idx = -1;
    foreach (mq[i]) if (!x_valid && mq[i].opened) begin
      x_valid = 1; x_acc = 1; x_idx = i;
    end
    if (!x_valid) foreach (mq[i])
      if (!x_valid && !mq[i].opened && !mbusy[mq[i].bank * 8 + mq[i].sub]) begin
        x_valid = 1; x_idx = i;
      end
    x_ready = (mq.size() < 16);
  endfunction

  function automatic void model_update();
    bit hs, take, do_set;
    int set_slot;
    req_t n;
    hs = x_valid && cmd_ready;
    take = enq_valid && x_ready;
    do_set = 0; set_slot = 0;
    if (hs) begin
      if (x_acc) mq.delete(x_idx);
      else begin
        mq[x_idx].opened = 1;
        do_set = 1;
        set_slot = mq[x_idx].bank * 8 + mq[x_idx].sub;
      end
    end
    if (cpl_valid) mbusy[int'(cpl_bank) * 8 + int'(cpl_sub)] = 0;
    if (do_set) mbusy[set_slot] = 1;
    if (take) begin
      n.orient = enq_orient; n.bank = int'(enq_bank); n.sub = int'(enq_sub);
      n.addr = enq_addr; n.wr = enq_write; n.opened = 0;
      mq.push_back(n);
    end
  endfunction

  task automatic compare();
    logic [41:0] got, exp;
    got = '0; exp = '0;
    got[41] = cmd_valid; got[40] = enq_ready;
    if (cmd_valid)
      got[39:0] = {cmd_access, cmd_orient, cmd_bank, cmd_sub, cmd_write, cmd_addr};
    exp[41] = x_valid; exp[40] = x_ready;
    if (x_valid)
      exp[39:0] = {x_acc, mq[x_idx].orient, 2'(mq[x_idx].bank), 3'(mq[x_idx].sub),
                   mq[x_idx].wr, mq[x_idx].addr};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%h expected=%h", cur_req, $time, got, exp);
    end
  endtask

  // one clock: inputs already set, compare away from the edge, then step model
  task automatic cycle();
    #1;
    model_eval();
    compare();
    @(posedge clk);
    model_update();
    @(negedge clk);
    enq_valid = 0;
    cpl_valid = 0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cycle();
  endtask

  task automatic put(bit o, int b, int s, logic [31:0] a, bit w);
    enq_valid = 1; enq_orient = o; enq_bank = 2'(b); enq_sub = 3'(s);
    enq_addr = a; enq_write = w;
    cycle();
  endtask

  task automatic done(int b, int s);
    cpl_valid = 1; cpl_bank = 2'(b); cpl_sub = 3'(s);
    cycle();
  endtask

  task automatic direct_check(string req, bit cond, logic [7:0] act_v, logic [7:0] exp_v);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  initial begin
    #(20ns * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    direct_check("R1", enq_ready === 1'b1 && cmd_valid === 1'b0,
                 {6'd0, enq_ready, cmd_valid}, 8'h02);
    rst_n = 1;
    cur_req = "R1"; idle(2);

    // R2 R3: one request, activate then access
    cur_req = "R2"; put(0, 1, 3, 32'h0000_1230, 0);
    cur_req = "R3"; idle(3);
    done(1, 3);

    // R4: row then column to the same subarray serialize
    cur_req = "R4";
    put(0, 2, 5, 32'h0000_2000, 1);
    put(1, 2, 5, 32'h0000_2008, 0);
    idle(4);
    direct_check("R4", cmd_valid === 1'b0, {7'd0, cmd_valid}, 8'h00);
    done(2, 5);
    idle(3);
    done(2, 5);

    // R5 R6: other subarrays of the same bank proceed, accesses first
    cur_req = "R5";
    put(0, 0, 1, 32'h0000_3000, 0);
    put(1, 0, 2, 32'h0000_3100, 1);
    put(1, 0, 1, 32'h0000_3200, 0);
    cur_req = "R6"; idle(5);
    done(0, 2);
    cur_req = "R5"; done(0, 1);
    idle(3);
    done(0, 1);

    // R7 R9: build a backlog under stall, then release
    cur_req = "R9"; cmd_ready = 0;
    put(0, 3, 0, 32'h0000_4000, 0);
    put(1, 3, 1, 32'h0000_4010, 1);
    put(0, 3, 0, 32'h0000_4020, 1);
    put(1, 1, 7, 32'h0000_4030, 0);
    idle(3);
    cur_req = "R7"; cmd_ready = 1;
    idle(8);
    done(3, 1); done(1, 7); done(3, 0);
    idle(3);
    done(3, 0);

    // R8: fill the queue while stalled, extra requests ignored
    cur_req = "R8"; cmd_ready = 0;
    for (int k = 0; k < 18; k++) put(k[0], k % 4, (k / 4) % 8, 32'h5000 + 32'(k), k[1]);
    direct_check("R8", enq_ready === 1'b0, {7'd0, enq_ready}, 8'h00);
    cmd_ready = 1;

    // R10: completion for an idle pair leaves a blocked request blocked
    cur_req = "R10";
    for (int k = 0; k < 60; k++) cycle();
    for (int b = 0; b < 4; b++) for (int s = 0; s < 8; s++) if (mbusy[b * 8 + s]) done(b, s);
    idle(40);
    for (int b = 0; b < 4; b++) for (int s = 0; s < 8; s++) if (mbusy[b * 8 + s]) done(b, s);
    idle(10);
    put(0, 2, 6, 32'h0000_6000, 0);
    put(1, 2, 6, 32'h0000_6004, 0);
    idle(3);
    done(1, 1);
    idle(2);
    // completion and new activate to the same pair in one cycle
    put(0, 3, 3, 32'h0000_6100, 0);
    cpl_valid = 1; cpl_bank = 2'd3; cpl_sub = 3'd3;
    cycle();
    idle(3);
    done(2, 6); idle(3); done(2, 6); done(3, 3);

    // mixed traffic, R7 ordering with random back-pressure and completions
    cur_req = "R7";
    for (int k = 0; k < 4000; k++) begin
      int bl[$];
      enq_valid = ($urandom % 3) != 0;
      enq_orient = 1'($urandom); enq_bank = 2'($urandom); enq_sub = 3'($urandom);
      enq_addr = $urandom; enq_write = 1'($urandom);
      cmd_ready = ($urandom % 4) != 0;
      foreach (mbusy[i]) if (mbusy[i]) bl.push_back(i);
      if (($urandom % 3) == 0) begin
        int pick;
        pick = (bl.size() > 0 && ($urandom % 5) != 0) ? bl[$urandom % bl.size()] : int'($urandom % 32);
        cpl_valid = 1; cpl_bank = 2'(pick / 8); cpl_sub = 3'(pick % 8);
      end
      cycle();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule